// File: doc/BRIEF.md
# Shift-Window Oversampling Serial Receiver

This block receives asynchronous serial characters made of one start bit, eight data bits sent least significant bit first, and a stop bit. The line input first passes through a two-flop synchronizer. A programmable divider then produces a sample tick at five times the bit rate. On each tick the synchronized line level is shifted into a sample window that is five samples per bit wide and covers the start bit plus the eight data bits. The design finds a start by looking for a fixed pattern at the old end of the window. It then reads the whole byte at once, from fixed sample positions near the middle of each bit slot. It does not follow each bit with a state machine.

After a capture, the receiver ignores further start patterns for one full window length of ticks. The window keeps shifting during this time, so it is already full when searching resumes. The stop bit is never examined. Captured bytes leave through a valid/ready stream port towards a receive FIFO. This port holds one byte. While that byte waits for `m_ready_i`, the held byte and its valid stay unchanged. A byte captured in that time is discarded and the held byte is kept. A byte is offered only while the receive enable input is high.

Top module: `serial_window_rx`

## Requirements
- R1: The sample tick repeats every `div_i`+1 clock cycles. A character whose bit period is 5·(`div_i`+1) clocks is received correctly for any divisor, including 0.
- R2: The line input reaches the window through two synchronizer flops that reset to 1. After reset the window holds all ones, so an idle high line produces no byte.
- R3: On each tick the window shifts toward index 0 and the newest sample enters at the top index (44 by default). A start is recognized on a tick when window bits [2:0] equal 3'b001, which means bit 0 is 1 and bits 1 and 2 are 0.
- R4: Data bit k (k = 0 is the least significant bit) is taken from window index 5·(k+1)+2, for k = 0 to 7. The byte appears on `m_data_o`.
- R5: The stop bit is not examined. A character whose stop bit is low is still delivered with its data.
- R6: After a capture, start patterns are ignored for 45 ticks. A falling edge inside the captured data (for example byte 0x01) gives no extra byte. A character that follows directly after a one-bit stop is still received.
- R7: While `rx_en_i` is low, captured characters are not offered on the output port.
- R8: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o` stays high and `m_data_o` is stable. A byte captured during this time is discarded. A transfer takes place on a clock edge where both are high.
- R9: Reset clears `m_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line input, idle high |
| rx_en_i | input | 1 | Receive enable; when low, bytes are not offered |
| div_i | input | DIV_W (10) | Sample divisor; tick period is div_i+1 clocks |
| m_data_o | output | DATA_W (8) | Received byte |
| m_valid_o | output | 1 | Received byte is valid |
| m_ready_i | input | 1 | Downstream accepts the byte |

## Verification
The bench builds the block with its default parameters: a 10-bit divisor, five samples per bit and eight data bits, which gives the 45-sample window. At run time it uses the divisors 0, 3 and 7, so a character is only 5, 20 or 40 clocks per bit. This brings many characters, back-to-back frames and the full 45-tick hold-off into a short run. Vectors with a low stop bit show that the stop bit is ignored. A byte with a falling edge inside its data shows that no false start is taken during the hold-off. Back-pressure and the receive enable are tested with pairs of characters.

// File: rtl/swrx_pkg.sv
`timescale 1ns/1ps
package swrx_pkg;
  // Window length: start slot plus data slots, each OSR samples wide.
  function automatic int win_len(input int osr, input int data_bits);
    return osr * (data_bits + 1);
  endfunction

  // Sample offset within a bit slot used for the data decision.
  function automatic int mid_off(input int osr);
    return osr / 2;
  endfunction
endpackage

// File: rtl/swrx_sync.sv
`timescale 1ns/1ps
module swrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swrx_tick.sv
`timescale 1ns/1ps
module swrx_tick #(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/swrx_window.sv
`timescale 1ns/1ps
module swrx_window #(
  parameter int OSR    = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              cap_o,
  output logic [DATA_W-1:0] byte_o
);
  import swrx_pkg::*;

  localparam int WIN_W  = win_len(OSR, DATA_W);
  localparam int MID    = mid_off(OSR);
  localparam int HOLD_W = $clog2(WIN_W + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(WIN_W);

  logic [WIN_W-1:0]  win_q;
  logic [HOLD_W-1:0] hold_q;
  logic              start_seen;
  logic              searching;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '1;
    else if (tick_i) win_q <= {line_i, win_q[WIN_W-1:1]};
  end

  assign start_seen = (win_q[2:0] == 3'b001);
  assign searching  = (hold_q == '0);
  assign cap_o      = tick_i && searching && start_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= '0;
    else if (cap_o)                  hold_q <= HOLD_LOAD;
    else if (tick_i && !searching)   hold_q <= hold_q - 1'b1;
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_pick
    assign byte_o[k] = win_q[OSR * (k + 1) + MID];
  end
endmodule

// File: rtl/swrx_outreg.sv
`timescale 1ns/1ps
module swrx_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_req_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_valid_o,
  input  logic              m_ready_i
);
  logic room;
  logic load;

  assign room = !m_valid_o || m_ready_i;
  assign load = load_req_i && room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
    end else if (load) begin
      m_valid_o <= 1'b1;
      m_data_o  <= load_data_i;
    end else if (m_ready_i) begin
      m_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_window_rx.sv
`timescale 1ns/1ps
module serial_window_rx #(
  parameter int DIV_W  = 10,
  parameter int OSR    = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_valid_o,
  input  logic              m_ready_i
);
  logic              line_s;
  logic              tick_w;
  logic              cap_w;
  logic [DATA_W-1:0] byte_w;

  swrx_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(line_s)
  );

  swrx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick_w)
  );

  swrx_window #(.OSR(OSR), .DATA_W(DATA_W)) u_win (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .line_i(line_s),
    .cap_o (cap_w), .byte_o(byte_w)
  );

  swrx_outreg #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_req_i (cap_w && rx_en_i),
    .load_data_i(byte_w),
    .m_data_o   (m_data_o),
    .m_valid_o  (m_valid_o),
    .m_ready_i  (m_ready_i)
  );
endmodule

// File: rtl/serial_window_rx_chk.sv
`timescale 1ns/1ps
module serial_window_rx_chk #(
  parameter int DIV_W  = 10,
  parameter int OSR    = 5,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              capture,
  input logic              rx_en,
  input logic [DIV_W-1:0]  div,
  input logic [DATA_W-1:0] data,
  input logic              valid,
  input logic              ready
);
  localparam int WIN_W = OSR * (DATA_W + 1);
  localparam int SW    = $clog2(WIN_W + 1);

  logic [DIV_W:0]   gap_q;
  logic             seen_tick_q;
  logic             div_chg_q;
  logic [DIV_W-1:0] div_q;
  logic [SW-1:0]    since_q;
  logic             seen_cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0; seen_tick_q <= 1'b0; div_chg_q <= 1'b0; div_q <= '0;
      since_q <= '0; seen_cap_q <= 1'b0;
    end else begin
      div_q <= div;
      if (tick) begin
        gap_q       <= '0;
        seen_tick_q <= 1'b1;
        div_chg_q   <= 1'b0;
      end else begin
        gap_q     <= gap_q + 1'b1;
        div_chg_q <= div_chg_q || (div != div_q);
      end
      if (capture) begin
        since_q    <= '0;
        seen_cap_q <= 1'b1;
      end else if (tick && since_q != SW'(WIN_W)) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && seen_tick_q && !div_chg_q && div == div_q) |-> (gap_q == {1'b0, div})); // R1

  AST_CAPTURE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |-> tick); // R3

  AST_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture && seen_cap_q) |-> (since_q >= SW'(WIN_W))); // R6

  AST_NO_PUSH_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid) |-> $past(rx_en)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && !ready) |=> (valid && $stable(data))); // R8
endmodule

bind serial_window_rx serial_window_rx_chk #(.DIV_W(DIV_W), .OSR(OSR), .DATA_W(DATA_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick   (tick_w),
  .capture(cap_w),
  .rx_en  (rx_en_i),
  .div    (div_i),
  .data   (m_data_o),
  .valid  (m_valid_o),
  .ready  (m_ready_i)
);

// File: tb/serial_window_rx_tb_top.sv
`timescale 1ns/1ps
module serial_window_rx_tb_top;
  localparam int DIV_W = 10;
  localparam int NVEC  = 8;
  // Vector: [18:9] divisor, [8] stop bit level, [7:0] byte
  localparam logic [18:0] VEC [NVEC] = '{
    {10'd3, 1'b1, 8'hA5},
    {10'd3, 1'b1, 8'h00},
    {10'd3, 1'b1, 8'hFF},
    {10'd0, 1'b1, 8'h5A},
    {10'd0, 1'b1, 8'h01},
    {10'd7, 1'b1, 8'h80},
    {10'd3, 1'b0, 8'h3C},
    {10'd0, 1'b0, 8'hC3}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rxd = 1'b1;
  logic             rx_en = 1'b1;
  logic [DIV_W-1:0] div = 10'd3;
  logic [7:0]       m_data;
  logic             m_valid;
  logic             m_ready = 1'b1;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] rx_log [64];
  int rx_n = 0;

  always #10 clk = ~clk;

  serial_window_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .rx_en_i(rx_en), .div_i(div),
    .m_data_o(m_data), .m_valid_o(m_valid), .m_ready_i(m_ready)
  );

  // Transfer monitor, sampled between edges
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready && rx_n < 64) begin
      rx_log[rx_n] = m_data;
      rx_n = rx_n + 1;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  function automatic int bitclk();
    return 5 * (int'(div) + 1);
  endfunction

  task automatic send_frame(input logic [7:0] b, input logic stopb);
    rxd = 1'b0; step(bitclk());
    for (int k = 0; k < 8; k++) begin
      rxd = b[k]; step(bitclk());
    end
    rxd = stopb; step(bitclk());
    rxd = 1'b1;
  endtask

  initial begin
    int n0;
    step(3);
    rst_n = 1'b1;
    #1;
    check(m_valid == 1'b0, "R9 valid after reset", m_valid, 0);
    step(200);
    check(rx_n == 0, "R2 idle line gives no byte", rx_n, 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      div = VEC[i][18:9];
      step(2 * bitclk());
      n0 = rx_n;
      send_frame(VEC[i][7:0], VEC[i][8]);
      step(3 * bitclk());
      check(rx_n == n0 + 1, "R1/R3/R6 byte count", rx_n - n0, 1);
      check(rx_log[n0] == VEC[i][7:0],
            VEC[i][8] ? "R4 data" : "R5 data with low stop", rx_log[n0], VEC[i][7:0]);
    end

    // Back-to-back frames
    div = 10'd3;
    step(2 * bitclk());
    n0 = rx_n;
    send_frame(8'h12, 1'b1);
    send_frame(8'h34, 1'b1);
    step(3 * bitclk());
    check(rx_n == n0 + 2, "R6 back-to-back count", rx_n - n0, 2);
    check(rx_log[n0] == 8'h12, "R6 first byte", rx_log[n0], 8'h12);
    check(rx_log[n0+1] == 8'h34, "R6 second byte", rx_log[n0+1], 8'h34);

    // Receive enable
    rx_en = 1'b0;
    n0 = rx_n;
    send_frame(8'h55, 1'b1);
    step(3 * bitclk());
    check(rx_n == n0 && m_valid == 1'b0, "R7 disabled no byte", rx_n - n0, 0);
    rx_en = 1'b1;
    step(bitclk());
    send_frame(8'h66, 1'b1);
    step(3 * bitclk());
    check(rx_n == n0 + 1, "R7 enabled count", rx_n - n0, 1);
    check(rx_log[n0] == 8'h66, "R7 enabled data", rx_log[n0], 8'h66);

    // Back-pressure
    m_ready = 1'b0;
    n0 = rx_n;
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    step(3 * bitclk());
    check(m_valid == 1'b1, "R8 valid held", m_valid, 1);
    check(m_data == 8'h11, "R8 held data kept", m_data, 8'h11);
    m_ready = 1'b1;
    step(1);
    m_ready = 1'b1;
    step(2);
    check(m_valid == 1'b0, "R8 drained", m_valid, 0);
    check(rx_n == n0 + 1 && rx_log[n0] == 8'h11, "R8 late byte discarded",
          rx_n - n0, 1);

    // Reset while a byte is held
    m_ready = 1'b0;
    send_frame(8'h77, 1'b1);
    step(3 * bitclk());
    check(m_valid == 1'b1, "R8 valid before reset", m_valid, 1);
    rst_n = 1'b0;
    #1;
    check(m_valid == 1'b0, "R9 reset clears valid", m_valid, 0);
    step(2);
    rst_n = 1'b1;
    m_ready = 1'b1;
    step(2);

    finish_run();
  end
endmodule